// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block collects sixteen interrupt sources for a processor core. Each source event is held in a flag register until it is serviced or cleared. A flag produces a request only when the source's own enable bit and the global enable bit are both set. Position 0 is the exception: it stands for reset and is never masked. The controller presents one request line and the number of the winning source. When several sources are pending, the lowest-numbered one wins.

When the core acknowledges a request, the controller clears the winning source's flag. In the same step it copies the global enable into a saved bit and turns the global enable off. The core uses the vector number to branch to the matching routine and to save its return location. A return-from-interrupt pulse puts the saved global enable back. Software reads and writes the flag, enable and global bits through a small register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the flags, the per-source enables, the global enable and the saved enable all read 0, and `irqReq` is 0.
- R2: A cycle with `srcEvent[i]` high sets flag i, and the new flag is readable from the next cycle on.
- R3: Register select 0 sets the flags whose bits are 1 in the written data. Select 1 clears them. Select 2 writes the enables. Select 3 bit 0 writes the global enable. Selects 0 and 1 read the flags, select 2 reads the enables, and select 3 reads {saved enable at bit 1, global enable at bit 0}. A source event overrides a clear of the same flag in the same cycle.
- R4: A source i other than 0 raises `irqReq` only when its flag, its enable bit and the global enable are all 1. While the global enable is 0, no such source raises a request.
- R5: When several sources may raise a request, `irqVector` gives the lowest-numbered one.
- R6: A set flag 0 raises `irqReq` with vector 0 whatever its enable bit and the global enable hold.
- R7: `irqAck` while `irqReq` is high clears the flag of the source named by `irqVector`. It also copies the global enable into the saved enable and sets the global enable to 0, all visible in the next cycle.
- R8: A pulse on `irqReturn` loads the global enable from the saved enable.
- R9: `irqAck` while `irqReq` is low changes no flag and leaves the global enable unchanged.
- R10: A source event in the same cycle as the acknowledge of that source leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcEvent | input | 16 | Per-source event pulses |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 set flags, 1 clear flags, 2 enables, 3 global) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for `regSel` |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 4 | Number of the winning source |
| irqAck | input | 1 | Core acknowledge |
| irqReturn | input | 1 | Return-from-interrupt pulse |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a source event lands in the same cycle as a clear of that flag. In the other, it lands in the same cycle as the acknowledge that clears it. The stimulus drives the event and the write or acknowledge on the same falling edge so that all of them take effect at one rising edge. It then reads the flag back through the register port. The bench also acknowledges the unmaskable position while the global enable is off. This checks that the saved enable captures 0 and that a return restores 0 and not 1.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_N = 16;
  localparam int VEC_W = $clog2(IRQ_N);

  typedef enum logic [1:0] {
    SEL_SET  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_GLOB = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             ack;
    logic [VEC_W-1:0] ackVec;
    logic             ret;
    logic             setWr;
    logic             clrWr;
    logic             enWr;
    logic             gieWr;
  } ctrl_strb_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_strb_t       strb,
  input  logic [IRQ_N-1:0] srcEvent,
  input  logic [IRQ_N-1:0] wrData,
  input  logic [1:0]       regSel,
  output logic [IRQ_N-1:0] rdData,
  output logic [IRQ_N-1:0] flags,
  output logic [IRQ_N-1:0] enables,
  output logic             gie,
  output logic             savedGie
);
  logic [IRQ_N-1:0] flagsNext;
  logic [IRQ_N-1:0] ackMask;

  always_comb begin
    ackMask = '0;
    ackMask[strb.ackVec] = strb.ack;
    flagsNext = flags;
    if (strb.setWr) flagsNext = flagsNext | wrData;
    if (strb.clrWr) flagsNext = flagsNext & ~wrData;
    flagsNext = flagsNext & ~ackMask;
    flagsNext = flagsNext | srcEvent;   // hardware events win
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags    <= '0;
      enables  <= '0;
      gie      <= 1'b0;
      savedGie <= 1'b0;
    end else begin
      flags <= flagsNext;
      if (strb.enWr) enables <= wrData;
      if (strb.ack) begin
        savedGie <= gie;
        gie      <= 1'b0;
      end else if (strb.ret) begin
        gie <= savedGie;
      end else if (strb.gieWr) begin
        gie <= wrData[0];
      end
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_EN:   rdData = enables;
      SEL_GLOB: rdData = {{(IRQ_N-2){1'b0}}, savedGie, gie};
      default:  rdData = flags;
    endcase
  end

  // R7: global enable is off in the cycle after an acknowledge
  a_r7_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ack |=> !gie);
  // R8: a return without an acknowledge restores the saved enable
  a_r8_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ret && !strb.ack) |=> (gie == $past(savedGie)));
  // R2: an event flag is held in the next cycle
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (srcEvent != '0) |=> ((flags & $past(srcEvent)) == $past(srcEvent)));
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irqAck,
  input  logic             irqReturn,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [IRQ_N-1:0] flags,
  input  logic [IRQ_N-1:0] enables,
  input  logic             gie,
  output ctrl_strb_t       strb,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector
);
  logic [IRQ_N-1:0] eligible;

  always_comb begin
    eligible    = flags & enables & {IRQ_N{gie}};
    eligible[0] = flags[0];             // reset position is never masked
    irqVector   = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (eligible[i]) irqVector = VEC_W'(i);
    end
    irqReq = |eligible;
  end

  always_comb begin
    strb        = '0;
    strb.ack    = irqAck && irqReq;
    strb.ackVec = irqVector;
    strb.ret    = irqReturn;
    strb.setWr  = regWrEn && (regSel == SEL_SET);
    strb.clrWr  = regWrEn && (regSel == SEL_CLR);
    strb.enWr   = regWrEn && (regSel == SEL_EN);
    strb.gieWr  = regWrEn && (regSel == SEL_GLOB);
  end

  // R4: a non-zero winner is flagged, enabled and globally allowed
  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && irqVector != '0) |-> (gie && enables[irqVector] && flags[irqVector]));
  // R5: the reported source is pending
  a_r5_vector_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> flags[irqVector]);
  // R6: flag 0 always wins and always requests
  a_r6_zero_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] |-> (irqReq && irqVector == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] srcEvent,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [IRQ_N-1:0] regWrData,
  output logic [IRQ_N-1:0] regRdData,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  input  logic             irqAck,
  input  logic             irqReturn
);
  ctrl_strb_t       strb;
  logic [IRQ_N-1:0] flags;
  logic [IRQ_N-1:0] enables;
  logic             gie;
  logic             savedGie;

  irq_control ctrl_i (
    .clk(clk), .rst_n(rst_n), .irqAck(irqAck), .irqReturn(irqReturn),
    .regWrEn(regWrEn), .regSel(regSel), .flags(flags), .enables(enables),
    .gie(gie), .strb(strb), .irqReq(irqReq), .irqVector(irqVector)
  );

  irq_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .srcEvent(srcEvent),
    .wrData(regWrData), .regSel(regSel), .rdData(regRdData),
    .flags(flags), .enables(enables), .gie(gie), .savedGie(savedGie)
  );
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] srcEvent = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqReq;
  logic [3:0]  irqVector;
  logic        irqAck = 1'b0;
  logic        irqReturn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .srcEvent(srcEvent), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .irqVector(irqVector), .irqAck(irqAck),
    .irqReturn(irqReturn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] data);
    regSel = sel;
    #1 data = regRdData;
  endtask

  task automatic pulseEvent(input logic [15:0] ev);
    srcEvent = ev;
    tick();
    srcEvent = '0;
  endtask

  task automatic cleanSlate();
    wr(2'd3, 16'h0);
    wr(2'd2, 16'h0);
    wr(2'd1, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    #1 chk("R1 irqReq", irqReq, 0);
    rd(2'd0, v); chk("R1 flags", v, 0);
    rd(2'd2, v); chk("R1 enables", v, 0);
    rd(2'd3, v); chk("R1 global", v, 0);
  endtask

  task automatic t_event_masked();
    logic [15:0] v;
    pulseEvent(16'h0020);
    rd(2'd0, v); chk("R2 flag5 latched", v, 16'h0020);
    chk("R4 no req when disabled", irqReq, 0);
    wr(2'd2, 16'h0020);
    chk("R4 no req when gie off", irqReq, 0);
    wr(2'd3, 16'h0001);
    chk("R4 req when all set", irqReq, 1);
    chk("R4 vector 5", irqVector, 5);
    wr(2'd2, 16'h0000);
    chk("R4 enable cleared drops req", irqReq, 0);
    cleanSlate();
  endtask

  task automatic t_priority();
    logic [15:0] v;
    wr(2'd2, 16'hFFFE);
    wr(2'd0, 16'h0228);
    wr(2'd3, 16'h0001);
    chk("R5 req", irqReq, 1);
    chk("R5 lowest wins", irqVector, 3);
    irqAck = 1'b1; tick(); irqAck = 1'b0;
    rd(2'd0, v); chk("R7 flag3 cleared", v, 16'h0220);
    rd(2'd3, v); chk("R7 gie off saved on", v, 16'h0002);
    chk("R4 no req while gie off", irqReq, 0);
    irqReturn = 1'b1; tick(); irqReturn = 1'b0;
    rd(2'd3, v); chk("R8 gie restored", v[0], 1);
    chk("R5 next winner", irqVector, 5);
    cleanSlate();
  endtask

  task automatic t_zero();
    logic [15:0] v;
    wr(2'd0, 16'h0001);
    chk("R6 req with masks off", irqReq, 1);
    chk("R6 vector 0", irqVector, 0);
    irqAck = 1'b1; tick(); irqAck = 1'b0;
    rd(2'd0, v); chk("R7 flag0 cleared", v, 0);
    rd(2'd3, v); chk("R7 saved captures 0", v, 0);
    wr(2'd3, 16'h0001);
    irqReturn = 1'b1; tick(); irqReturn = 1'b0;
    rd(2'd3, v); chk("R8 return restores 0", v, 0);
    cleanSlate();
  endtask

  task automatic t_swflags();
    logic [15:0] v;
    wr(2'd0, 16'h0880);
    rd(2'd1, v); chk("R3 sw set", v, 16'h0880);
    wr(2'd1, 16'h0800);
    rd(2'd0, v); chk("R3 sw clear", v, 16'h0080);
    srcEvent = 16'h0080; regWrEn = 1'b1; regSel = 2'd1; regWrData = 16'h0080;
    tick();
    srcEvent = '0; regWrEn = 1'b0; regWrData = '0;
    rd(2'd0, v); chk("R3 event beats clear", v, 16'h0080);
    cleanSlate();
  endtask

  task automatic t_ack_idle();
    logic [15:0] v;
    wr(2'd0, 16'h0100);
    wr(2'd3, 16'h0001);
    chk("R9 no req", irqReq, 0);
    irqAck = 1'b1; tick(); irqAck = 1'b0;
    rd(2'd0, v); chk("R9 flags unchanged", v, 16'h0100);
    rd(2'd3, v); chk("R9 gie unchanged", v, 16'h0001);
    cleanSlate();
  endtask

  task automatic t_ack_event();
    logic [15:0] v;
    wr(2'd2, 16'h0010);
    wr(2'd0, 16'h0010);
    wr(2'd3, 16'h0001);
    chk("R10 req vector 4", irqVector, 4);
    irqAck = 1'b1; srcEvent = 16'h0010;
    tick();
    irqAck = 1'b0; srcEvent = '0;
    rd(2'd0, v); chk("R10 flag4 kept", v, 16'h0010);
    rd(2'd3, v); chk("R10 gie off", v[0], 0);
    cleanSlate();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_event_masked();
    t_priority();
    t_zero();
    t_swflags();
    t_ack_idle();
    t_ack_event();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule